// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits on the host write path in front of a page-write engine. It watches every write request (address and data) and picks out short command sequences. The sequences are matched on the low address bits and on fixed data values. A three-write unlock sequence does two things: it arms write protection, and it opens a write window for the page load that follows. A six-write sequence switches protection off. Writes that form a matched command step are absorbed, so they never reach the array.

Every write that is not a command step gets a registered decision one cycle later. It is either forwarded to the engine with its address and data, or it is refused. A refused write raises a dummy-cycle request. The engine then runs its programming timer without storing anything, so host reads during that time behave like status polling. The engine reports the end of each programming cycle on `eng_done`. That pulse closes the write window, and it also completes a pending enable.

Top module: `sdp_seq`

## Requirements
- R1: After reset, `prot_on`, `fwd_valid` and `dummy_req` are all 0.
- R2: While protection is off, every write that is not a command step appears on `fwd_valid` with the same address and data one cycle after it is sampled, and `dummy_req` stays 0.
- R3: The enable sequence is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. All three writes are absorbed. `prot_on` stays 0 until the first `eng_done` pulse after the third write, and it reads 1 in the cycle after that pulse.
- R4: After the enable sequence, a write window stays open until the next `eng_done` pulse. Every write inside the window is forwarded, including a write of 0xAA to 0x5555.
- R5: While protection is on and no window is open, a write that is not a command step is not forwarded. `dummy_req` pulses for one cycle, one cycle after the write is sampled.
- R6: While protection is on, a write that directly follows the complete enable sequence is forwarded, and protection stays on.
- R7: The disable sequence is 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, then 0x20 at 0x5555. All six writes are absorbed, and `prot_on` reads 0 in the cycle after the last one.
- R8: A write that does not fit the expected next step returns the matcher to idle. That write is then judged as a new first step (0xAA at 0x5555) or as a data write.
- R9: Once set, `prot_on` stays 1 across any number of `eng_done` pulses and data writes, until the disable sequence completes.
- R10: Command matching uses only address bits 14:0. A sequence sent with bit 16 set is still recognised.
- R11: A matched command step never produces `fwd_valid` or `dummy_req`. This holds even for a prefix that is later abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A host write is presented this cycle |
| wr_addr | input | 17 | Host write address |
| wr_data | input | 8 | Host write data |
| eng_done | input | 1 | One-cycle pulse: the engine finished a programming cycle |
| prot_on | output | 1 | Write protection is active |
| fwd_valid | output | 1 | Forwarded write to the engine (one-cycle pulse) |
| fwd_addr | output | 17 | Address of the forwarded write |
| fwd_data | output | 8 | Data of the forwarded write |
| dummy_req | output | 1 | Refused write: run a timer-only cycle (one-cycle pulse) |

## Verification
The assertions take for granted that `eng_done` never arrives in the same cycle as a write. They also take for granted that `eng_done` is a single-cycle pulse. Because of this, the window and arming state seen by a write is always the value settled before that write. The bench drives each write and each `eng_done` pulse in a separate cycle, with idle cycles in between. It samples every decision one cycle after the write, on the falling clock edge.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  // Matcher progress through the command prefixes
  typedef enum logic [2:0] {
    M_IDLE = 3'd0,  // nothing matched
    M_K1   = 3'd1,  // first key seen
    M_K2   = 3'd2,  // second key seen
    M_E3   = 3'd3,  // erase-style third key seen (disable path)
    M_E4   = 3'd4,  // fourth key seen (disable path)
    M_E5   = 3'd5   // fifth key seen (disable path)
  } match_st_t;
endpackage

// File: rtl/sdp_cmd_match.sv
module sdp_cmd_match
  import sdp_pkg::*;
#(
  parameter int MATCH_W = 15,
  parameter int DATA_W  = 8,
  parameter int ADDR_P  = 'h5555,
  parameter int ADDR_Q  = 'h2AAA,
  parameter logic [DATA_W-1:0] KEY_1   = 'hAA,
  parameter logic [DATA_W-1:0] KEY_2   = 'h55,
  parameter logic [DATA_W-1:0] KEY_EN  = 'hA0,
  parameter logic [DATA_W-1:0] KEY_ER  = 'h80,
  parameter logic [DATA_W-1:0] KEY_DIS = 'h20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [MATCH_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               hold,      // window open: no matching
  output logic               cmd_hit,
  output logic               unlock,
  output logic               disarm
);
  localparam logic [MATCH_W-1:0] AP = MATCH_W'(ADDR_P);
  localparam logic [MATCH_W-1:0] AQ = MATCH_W'(ADDR_Q);

  match_st_t st, st_nx;
  logic at_p, at_q, first_key;

  assign at_p      = (cmd_addr == AP);
  assign at_q      = (cmd_addr == AQ);
  assign first_key = at_p && (wr_data == KEY_1);

  always_comb begin
    st_nx   = st;
    cmd_hit = 1'b0;
    unlock  = 1'b0;
    disarm  = 1'b0;
    if (hold) begin
      st_nx = M_IDLE;
    end else if (wr_valid) begin
      // default on departure: restart, possibly as a new first step
      st_nx   = first_key ? M_K1 : M_IDLE;
      cmd_hit = first_key;
      unique case (st)
        M_K1: if (at_q && wr_data == KEY_2) begin
          st_nx = M_K2; cmd_hit = 1'b1;
        end
        M_K2: if (at_p && wr_data == KEY_EN) begin
          st_nx = M_IDLE; cmd_hit = 1'b1; unlock = 1'b1;
        end else if (at_p && wr_data == KEY_ER) begin
          st_nx = M_E3; cmd_hit = 1'b1;
        end
        M_E3: if (first_key) begin
          st_nx = M_E4; cmd_hit = 1'b1;
        end
        M_E4: if (at_q && wr_data == KEY_2) begin
          st_nx = M_E5; cmd_hit = 1'b1;
        end
        M_E5: if (at_p && wr_data == KEY_DIS) begin
          st_nx = M_IDLE; cmd_hit = 1'b1; disarm = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= M_IDLE;
    else     st <= st_nx;
  end

  AST_UNLOCK_RETURNS_IDLE: assert property (@(posedge clk) disable iff (rst)
    unlock |=> (st == M_IDLE)); // R3
  AST_DISARM_FROM_FIFTH: assert property (@(posedge clk) disable iff (rst)
    disarm |-> (st == M_E5)); // R7
endmodule

// File: rtl/sdp_prot_state.sv
module sdp_prot_state (
  input  logic clk,
  input  logic rst,
  input  logic unlock,
  input  logic disarm,
  input  logic eng_done,
  output logic prot_on,
  output logic win_open
);
  logic arm_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_on  <= 1'b0;
      win_open <= 1'b0;
      arm_pend <= 1'b0;
    end else if (disarm) begin
      prot_on  <= 1'b0;
      win_open <= 1'b0;
      arm_pend <= 1'b0;
    end else if (unlock) begin
      win_open <= 1'b1;
      arm_pend <= 1'b1;
    end else if (eng_done) begin
      win_open <= 1'b0;
      arm_pend <= 1'b0;
      if (arm_pend) prot_on <= 1'b1;
    end
  end

  AST_ENABLE_LATE: assert property (@(posedge clk) disable iff (rst)
    (unlock && !prot_on) |=> !prot_on); // R3
  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (prot_on && !disarm) |=> prot_on); // R9
  AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (rst)
    disarm |=> !prot_on); // R7
endmodule

// File: rtl/sdp_write_gate.sv
module sdp_write_gate #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_hit,
  input  logic              prot_on,
  input  logic              win_open,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              dummy_req
);
  logic is_data, allowed;

  assign is_data = wr_valid && !cmd_hit;
  assign allowed = !prot_on || win_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      dummy_req <= 1'b0;
    end else begin
      fwd_valid <= is_data && allowed;
      dummy_req <= is_data && !allowed;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid) begin
      fwd_addr <= wr_addr;
      fwd_data <= wr_data;
    end
  end

  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && cmd_hit) |=> (!fwd_valid && !dummy_req)); // R11
  AST_LOCKED_DUMMY: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !cmd_hit && prot_on && !win_open) |=> (dummy_req && !fwd_valid)); // R5
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !cmd_hit && !prot_on) |=> (fwd_valid && fwd_data == $past(wr_data))); // R2
  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (rst)
    !(fwd_valid && dummy_req)); // R5
endmodule

// File: rtl/sdp_seq.sv
module sdp_seq #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int MATCH_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_done,
  output logic              prot_on,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              dummy_req
);
  logic cmd_hit, unlock, disarm, win_open;

  sdp_cmd_match #(.MATCH_W(MATCH_W), .DATA_W(DATA_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .cmd_addr (wr_addr[MATCH_W-1:0]),
    .wr_data  (wr_data),
    .hold     (win_open),
    .cmd_hit  (cmd_hit),
    .unlock   (unlock),
    .disarm   (disarm)
  );

  sdp_prot_state u_prot (
    .clk      (clk),
    .rst      (rst),
    .unlock   (unlock),
    .disarm   (disarm),
    .eng_done (eng_done),
    .prot_on  (prot_on),
    .win_open (win_open)
  );

  sdp_write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmd_hit   (cmd_hit),
    .prot_on   (prot_on),
    .win_open  (win_open),
    .fwd_valid (fwd_valid),
    .fwd_addr  (fwd_addr),
    .fwd_data  (fwd_data),
    .dummy_req (dummy_req)
  );

  AST_WINDOW_FORWARDS: assert property (@(posedge clk) disable iff (rst)
    (win_open && wr_valid && !eng_done) |=> (fwd_valid && !dummy_req)); // R4
endmodule

// File: tb/sim_sdp_seq.sv
`timescale 1ns/1ps
module sim_sdp_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        eng_done = 1'b0;
  logic        prot_on, fwd_valid, dummy_req;
  logic [16:0] fwd_addr;
  logic [7:0]  fwd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdp_seq u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_done(eng_done), .prot_on(prot_on),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .dummy_req(dummy_req)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // mode: 0 absorbed, 1 forwarded, 2 refused with dummy cycle
  task automatic wr(string req, logic [16:0] a, logic [7:0] d, int mode);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(req, "fwd_valid", int'(fwd_valid), int'(mode == 1));
    chk(req, "dummy_req", int'(dummy_req), int'(mode == 2));
    if (mode == 1) begin
      chk(req, "fwd_addr", int'(fwd_addr), int'(a));
      chk(req, "fwd_data", int'(fwd_data), int'(d));
    end
  endtask

  task automatic eng_pulse();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic unlock_seq(string req, logic [16:0] hi);
    wr(req, hi | 17'h05555, 8'hAA, 0);
    wr(req, hi | 17'h02AAA, 8'h55, 0);
    wr(req, hi | 17'h05555, 8'hA0, 0);
  endtask

  task automatic t_reset();
    chk("R1", "prot_on", int'(prot_on), 0);
    chk("R1", "fwd_valid", int'(fwd_valid), 0);
    chk("R1", "dummy_req", int'(dummy_req), 0);
  endtask

  task automatic t_plain();
    wr("R2", 17'h00123, 8'h5A, 1);
    wr("R2", 17'h1FFFF, 8'hFF, 1);
    wr("R2", 17'h02AAA, 8'h55, 1);
  endtask

  task automatic t_enable();
    unlock_seq("R3", 17'h0);
    chk("R3", "prot_on before end of cycle", int'(prot_on), 0);
    wr("R4", 17'h05555, 8'hAA, 1);
    wr("R4", 17'h00010, 8'h11, 1);
    eng_pulse();
    chk("R3", "prot_on after end of cycle", int'(prot_on), 1);
  endtask

  task automatic t_block();
    wr("R5", 17'h00200, 8'h33, 2);
    chk("R5", "prot_on", int'(prot_on), 1);
  endtask

  task automatic t_auth();
    unlock_seq("R6", 17'h0);
    wr("R6", 17'h00300, 8'h44, 1);
    eng_pulse();
    chk("R9", "prot_on after window", int'(prot_on), 1);
    eng_pulse();
    chk("R9", "prot_on after idle pulse", int'(prot_on), 1);
    wr("R5", 17'h00301, 8'h45, 2);
  endtask

  task automatic t_break();
    wr("R8", 17'h05555, 8'hAA, 0);
    wr("R8", 17'h02AAA, 8'h55, 0);
    wr("R8", 17'h00400, 8'h77, 2);
    wr("R8", 17'h05555, 8'hA0, 2);
    wr("R8", 17'h05555, 8'hAA, 0);
    wr("R8", 17'h05555, 8'hAA, 0);
    wr("R8", 17'h02AAA, 8'h55, 0);
    wr("R8", 17'h05555, 8'hA0, 0);
    wr("R8", 17'h00401, 8'h78, 1);
    eng_pulse();
    chk("R9", "prot_on", int'(prot_on), 1);
  endtask

  task automatic t_high();
    unlock_seq("R10", 17'h10000);
    wr("R10", 17'h10500, 8'h99, 1);
    eng_pulse();
    wr("R10", 17'h10501, 8'h9A, 2);
  endtask

  task automatic t_disable();
    wr("R7", 17'h05555, 8'hAA, 0);
    wr("R7", 17'h02AAA, 8'h55, 0);
    wr("R7", 17'h05555, 8'h80, 0);
    wr("R7", 17'h05555, 8'hAA, 0);
    wr("R7", 17'h02AAA, 8'h55, 0);
    chk("R7", "prot_on before last step", int'(prot_on), 1);
    wr("R7", 17'h05555, 8'h20, 0);
    chk("R7", "prot_on after last step", int'(prot_on), 0);
    wr("R7", 17'h00600, 8'h21, 1);
  endtask

  task automatic t_abandon();
    wr("R11", 17'h05555, 8'hAA, 0);
    wr("R11", 17'h00500, 8'h66, 1);
    wr("R11", 17'h05555, 8'hAA, 0);
    wr("R11", 17'h02AAA, 8'h55, 0);
    wr("R11", 17'h05555, 8'h80, 0);
    wr("R11", 17'h00501, 8'h67, 1);
    chk("R11", "prot_on", int'(prot_on), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_enable();
    t_block();
    t_auth();
    t_break();
    t_high();
    t_disable();
    t_abandon();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule